// File: doc/BRIEF.md
# Auxiliary Clock Divider with Receiver-Gated Output

This block derives an auxiliary clock from the reference clock that also runs the rest of the decoder. That reference runs at either 76.8 kHz or 160 kHz. Two configuration inputs pick the division. A low-frequency reference is halved. A high-frequency reference is either divided by four, which gives 40 kHz, or divided by an average of 25/6, which gives 38.4 kHz. The fractional ratio comes from a phase accumulator that places 12 output transitions in every 25 reference cycles. Each output phase therefore lasts either 2 or 3 reference cycles.

Two further controls shape what reaches the pin. A disable input forces the output low at once, and the change may cut a phase short. A burst-mode input ties the clock to the receiver. In burst mode the clock runs while the receiver is active. After the receiver reports that it has gone off, the clock continues for a fixed number of trailing periods. The gate opens and closes only at the point where the divided clock is about to rise, so burst mode never emits a short phase. The divider has no reset. When burst mode is clear, the output keeps toggling while the block reset is asserted. All inputs are level controls in the reference clock domain.

Top module: `aux_clk_div`

## Requirements
- R1: With `hi_ref_sel` low, `clk_out` toggles on every reference cycle, so every high and low phase lasts one cycle (reference / 2). The division does not depend on the reference frequency.
- R2: With `hi_ref_sel` high and `int_div_sel` high, every high and low phase of `clk_out` lasts exactly 2 reference cycles (reference / 4).
- R3: With `hi_ref_sel` high and `int_div_sel` low, every phase of `clk_out` lasts 2 or 3 reference cycles. Any 25 consecutive cycles hold exactly 12 transitions, so any 100 consecutive cycles hold 24 rising edges.
- R4: While `out_off` is high, `clk_out` is low from the first clock edge after it is sampled high.
- R5: With `burst_mode` low and `out_off` low, `clk_out` keeps dividing the reference while `rst_n` is low.
- R6: With `burst_mode` high, `clk_out` is low while `rst_n` is low. After reset it stays low for as long as `rx_off` stays high.
- R7: With `burst_mode` high, once `rx_off` is sampled low, `clk_out` rises within 6 reference cycles (divide-by-4 setting), and that first high phase has full length.
- R8: With `burst_mode` high, once `rx_off` is sampled high while the divided clock is low, exactly GUARD (default 4) further high pulses appear on `clk_out`, and then it stays low.
- R9: With `burst_mode` high and `hi_ref_sel` high, no high or low phase of `clk_out` is shorter than 2 reference cycles, including the phases next to a gate opening or closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (76.8 kHz or 160 kHz in the system) |
| rst_n | input | 1 | Active-low asynchronous reset of the gating state |
| hi_ref_sel | input | 1 | High: reference is the fast one, and the divider uses the /4 or fractional setting |
| int_div_sel | input | 1 | With `hi_ref_sel` high: 1 selects /4, 0 selects the fractional 25/6 ratio |
| out_off | input | 1 | Forces `clk_out` low |
| burst_mode | input | 1 | Gate the output by receiver activity with trailing guard periods |
| rx_off | input | 1 | Receiver reports its off state |
| clk_out | output | 1 | Divided auxiliary clock |

## Verification
On every cycle, the assertions check four things: that the fractional tick spacing stays within 2 to 3 cycles, that the output is held low under the disable, that the gate changes state only at a rising point of the divided clock, and that burst mode never produces a phase shorter than two cycles. Some behaviours can only be shown by the directed scenarios, which measure the output over windows. These are the exact transition counts per window, the division continuing through reset, the wake-up latency, and the exact number of trailing pulses after the receiver goes off.

// File: rtl/cko_pkg.sv
package cko_pkg;

  typedef enum logic [1:0] {
    CKO_DIV2 = 2'd0,
    CKO_DIV4 = 2'd1,
    CKO_FRAC = 2'd2
  } cko_mode_e;

  // Map the two configuration levels onto a division mode.
  function automatic cko_mode_e cko_pick_mode(input logic hi_ref, input logic int_div);
    if (!hi_ref)      return CKO_DIV2;
    else if (int_div) return CKO_DIV4;
    else              return CKO_FRAC;
  endfunction

endpackage

// File: rtl/cko_tick_gen.sv
module cko_tick_gen
  import cko_pkg::*;
#(
  parameter int HALF_SLOW = 1,
  parameter int HALF_FAST = 2,
  parameter int FRAC_NUM  = 12,
  parameter int FRAC_DEN  = 25
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cko_mode_e mode,
  output logic      tick
);
  localparam int HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CNT_W    = $clog2(HALF_MAX + 1);
  localparam int ACC_W    = $clog2(FRAC_NUM + FRAC_DEN + 1);

  // No reset: the divider keeps running while the gating logic is held.
  logic [CNT_W-1:0] cnt_q = '0;
  logic [ACC_W-1:0] acc_q = '0;
  logic [ACC_W-1:0] acc_sum;
  logic [CNT_W-1:0] half_lim;
  logic             int_tick;
  logic             frac_tick;

  always_comb begin
    half_lim  = (mode == CKO_DIV4) ? CNT_W'(HALF_FAST - 1) : CNT_W'(HALF_SLOW - 1);
    int_tick  = (cnt_q >= half_lim);
    acc_sum   = acc_q + ACC_W'(FRAC_NUM);
    frac_tick = (acc_sum >= ACC_W'(FRAC_DEN));
    tick      = (mode == CKO_FRAC) ? frac_tick : int_tick;
  end

  always_ff @(posedge clk) begin
    cnt_q <= int_tick ? '0 : cnt_q + CNT_W'(1);
    acc_q <= frac_tick ? acc_sum - ACC_W'(FRAC_DEN) : acc_sum;
  end

  // R3: fractional ticks never come back to back
  assert_frac_min_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CKO_FRAC && tick) ##1 (mode == CKO_FRAC) |-> !tick);

  // R3: fractional ticks never leave more than two idle cycles
  assert_frac_max_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CKO_FRAC && !tick) ##1 (mode == CKO_FRAC && !tick) ##1 (mode == CKO_FRAC)
    |-> tick);

endmodule

// File: rtl/cko_gate.sv
module cko_gate #(
  parameter int GUARD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic rx_off,
  input  logic rise_pt,
  output logic run
);
  localparam int GW = $clog2(GUARD + 1);

  logic [GW-1:0] guard_q;
  logic          run_q;

  // All state changes wait for a rising point of the divided clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      guard_q <= '0;
    end else if (rise_pt) begin
      if (!burst_mode || !rx_off) begin
        run_q   <= 1'b1;
        guard_q <= '0;
      end else if (run_q) begin
        if (guard_q == GW'(GUARD)) begin
          run_q   <= 1'b0;
          guard_q <= '0;
        end else begin
          guard_q <= guard_q + GW'(1);
        end
      end
    end
  end

  assign run = run_q;

  // R9: the gate opens or closes only at a rising point
  assert_gate_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_q) |-> $past(rise_pt));

  // R8: trailing guard count stays within its limit
  assert_guard_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q <= GW'(GUARD));

endmodule

// File: rtl/aux_clk_div.sv
module aux_clk_div
  import cko_pkg::*;
#(
  parameter int HALF_SLOW = 1,
  parameter int HALF_FAST = 2,
  parameter int FRAC_NUM  = 12,
  parameter int FRAC_DEN  = 25,
  parameter int GUARD     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_ref_sel,
  input  logic int_div_sel,
  input  logic out_off,
  input  logic burst_mode,
  input  logic rx_off,
  output logic clk_out
);
  cko_mode_e mode;
  logic      tick;
  logic      rise_pt;
  logic      run;
  logic      raw_q = 1'b0;
  logic      out_q = 1'b0;

  assign mode = cko_pick_mode(hi_ref_sel, int_div_sel);

  cko_tick_gen #(
    .HALF_SLOW (HALF_SLOW),
    .HALF_FAST (HALF_FAST),
    .FRAC_NUM  (FRAC_NUM),
    .FRAC_DEN  (FRAC_DEN)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .tick  (tick)
  );

  always_ff @(posedge clk) begin
    if (tick) raw_q <= ~raw_q;
  end

  assign rise_pt = tick && !raw_q;

  cko_gate #(
    .GUARD (GUARD)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_mode (burst_mode),
    .rx_off     (rx_off),
    .rise_pt    (rise_pt),
    .run        (run)
  );

  always_ff @(posedge clk) begin
    out_q <= raw_q & (~burst_mode | run) & ~out_off;
  end

  assign clk_out = out_q;

  // R4: disable forces the pin low on the next edge
  assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |=> !clk_out);

  // R1: slow setting toggles every cycle once settled
  assert_div2_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_ref_sel && !burst_mode && !out_off) ##1 (!hi_ref_sel && !burst_mode && !out_off)
    ##1 (!hi_ref_sel && !burst_mode && !out_off) |-> (clk_out != $past(clk_out)));

  // R9: burst mode never yields a one-cycle high phase
  assert_min_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && hi_ref_sel && !out_off && $rose(clk_out))
    ##1 (burst_mode && hi_ref_sel && !out_off && $stable(int_div_sel)) |-> clk_out);

  // R9: burst mode never yields a one-cycle low phase
  assert_min_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && hi_ref_sel && !out_off && $fell(clk_out))
    ##1 (burst_mode && hi_ref_sel && !out_off && $stable(int_div_sel)) |-> !clk_out);

endmodule

// File: tb/aux_clk_div_test.sv
`timescale 1ns/1ps
module aux_clk_div_test;
  logic clk = 1'b0;
  logic rst_n;
  logic hi_ref_sel, int_div_sel, out_off, burst_mode, rx_off;
  logic clk_out;
  int   tests = 0;
  int   fails = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  aux_clk_div uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_ref_sel  (hi_ref_sel),
    .int_div_sel (int_div_sel),
    .out_off     (out_off),
    .burst_mode  (burst_mode),
    .rx_off      (rx_off),
    .clk_out     (clk_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Sample at falling edges; report rising edges and complete phase lengths.
  task automatic measure(input int n, output int rises, output int hmin, output int hmax,
                         output int lmin, output int lmax);
    logic prev;
    int   run;
    bit   first;
    rises = 0; hmin = 1000; hmax = 0; lmin = 1000; lmax = 0; first = 1;
    @(negedge clk);
    prev = clk_out;
    run  = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out == prev) run++;
      else begin
        if (clk_out) rises++;
        if (!first) begin
          if (prev) begin
            if (run < hmin) hmin = run;
            if (run > hmax) hmax = run;
          end else begin
            if (run < lmin) lmin = run;
            if (run > lmax) lmax = run;
          end
        end
        first = 0;
        run   = 1;
      end
      prev = clk_out;
    end
  endtask

  task automatic wait_fall();
    logic prev;
    @(negedge clk);
    prev = clk_out;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (prev && !clk_out) return;
      prev = clk_out;
    end
  endtask

  task automatic test_reset_gated();
    int r, hn, hx, ln, lx;
    burst_mode = 1; rx_off = 1; rst_n = 0;
    cycles(3);
    measure(20, r, hn, hx, ln, lx);
    check(r == 0, "R6", "rises in reset, burst", r, 0);
    check(clk_out == 1'b0, "R6", "level in reset, burst", clk_out, 0);
  endtask

  task automatic test_toggle_in_reset();
    int r, hn, hx, ln, lx;
    burst_mode = 0;
    cycles(3);
    measure(40, r, hn, hx, ln, lx);
    check(r == 20, "R5", "rises during reset", r, 20);
    check(hn == 1 && hx == 1, "R5", "high phase in reset", hx, 1);
  endtask

  task automatic test_div2();
    int r, hn, hx, ln, lx;
    hi_ref_sel = 0;
    cycles(4);
    measure(100, r, hn, hx, ln, lx);
    check(r == 50, "R1", "rises per 100", r, 50);
    check(hn == 1 && hx == 1 && ln == 1 && lx == 1, "R1", "phase length", hx, 1);
  endtask

  task automatic test_div4();
    int r, hn, hx, ln, lx;
    hi_ref_sel = 1; int_div_sel = 1;
    cycles(4);
    measure(100, r, hn, hx, ln, lx);
    check(r == 25, "R2", "rises per 100", r, 25);
    check(hn == 2 && hx == 2, "R2", "high length", hn, 2);
    check(ln == 2 && lx == 2, "R2", "low length", ln, 2);
  endtask

  task automatic test_frac();
    int r, hn, hx, ln, lx;
    hi_ref_sel = 1; int_div_sel = 0;
    cycles(4);
    measure(100, r, hn, hx, ln, lx);
    check(r == 24, "R3", "rises per 100", r, 24);
    check(hn >= 2 && hx <= 3, "R3", "high length range", hx, 3);
    check(ln >= 2 && lx <= 3, "R3", "low length range", lx, 3);
    measure(25, r, hn, hx, ln, lx);
    check(r == 6, "R3", "rises per 25", r, 6);
  endtask

  task automatic test_disable();
    int r, hn, hx, ln, lx;
    hi_ref_sel = 1; int_div_sel = 1;
    cycles(4);
    out_off = 1;
    @(negedge clk);
    check(clk_out == 1'b0, "R4", "level after disable", clk_out, 0);
    measure(50, r, hn, hx, ln, lx);
    check(r == 0, "R4", "rises while disabled", r, 0);
    out_off = 0;
    cycles(4);
    measure(40, r, hn, hx, ln, lx);
    check(r == 10, "R4", "rises after re-enable", r, 10);
  endtask

  task automatic test_burst_idle();
    int r, hn, hx, ln, lx;
    hi_ref_sel = 1; int_div_sel = 1; burst_mode = 1; rx_off = 1;
    cycles(40);
    measure(60, r, hn, hx, ln, lx);
    check(r == 0, "R6", "rises with receiver off", r, 0);
  endtask

  task automatic test_burst_wake();
    int r, hn, hx, ln, lx, wait_n;
    rx_off = 0;
    wait_n = 0;
    while (!clk_out && wait_n < 20) begin
      @(negedge clk);
      wait_n++;
    end
    check(wait_n <= 6, "R7", "cycles to first rise", wait_n, 6);
    measure(40, r, hn, hx, ln, lx);
    check(r == 10, "R7", "rises after wake", r, 10);
    check(hn >= 2 && ln >= 2, "R9", "min phase after wake", hn, 2);
  endtask

  task automatic test_burst_stop();
    int r, hn, hx, ln, lx;
    wait_fall();
    rx_off = 1;
    measure(60, r, hn, hx, ln, lx);
    check(r == 4, "R8", "trailing pulses", r, 4);
    check(hn == 2, "R9", "trailing high length", hn, 2);
    check(clk_out == 1'b0, "R8", "level after guard", clk_out, 0);
  endtask

  task automatic test_burst_frac();
    int r, hn, hx, ln, lx;
    int_div_sel = 0; rx_off = 0;
    cycles(10);
    measure(75, r, hn, hx, ln, lx);
    check(r == 18, "R3", "fractional rises in burst", r, 18);
    check(hn >= 2 && ln >= 2, "R9", "fractional min phase", hn, 2);
    wait_fall();
    rx_off = 1;
    measure(80, r, hn, hx, ln, lx);
    check(r >= 4 && r <= 5, "R8", "fractional trailing pulses", r, 4);
    check(hn >= 2, "R9", "fractional trailing high", hn, 2);
    check(clk_out == 1'b0, "R8", "fractional level after guard", clk_out, 0);
  endtask

  initial begin
    rst_n = 0; hi_ref_sel = 0; int_div_sel = 0; out_off = 0;
    burst_mode = 0; rx_off = 0;
    test_reset_gated();
    test_toggle_in_reset();
    rst_n = 1;
    test_div2();
    test_div4();
    test_frac();
    test_disable();
    test_burst_idle();
    test_burst_wake();
    test_burst_stop();
    test_burst_frac();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule